// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into start/stop framed serial data on one output line. A one-character holding register sits in front of the frame shifter. Software can therefore write the next character while the current frame is still going out, and consecutive frames leave the line with no idle time between them.

The bit timing comes from an external bit-clock enable. That enable runs at 1, 16 or 64 times the baud rate. Each bit lasts the matching number of enable pulses.

The character length, the parity mode and the stop-bit count are taken from the configuration inputs at the moment a character moves into the shifter. Two flags report the state of the block:
- A ready flag says that the holding register can accept a byte.
- An empty flag says that no frame is being shifted out.

A separate sticky flag records any write that arrived while the holding register was full.

Top module: `async_tx_core`

## Requirements
- R1: After reset, `txd_o`=1, `tx_rdy_o`=1, `tx_empty_o`=1 and `overrun_o`=0. Reset also clears a set `overrun_o`.
- R2: A frame is sent in this order: one start bit of 0, then the data bits least significant first, then the parity bit if enabled, then stop bits of 1. The line rests at 1 when idle.
- R3: `char_len_i` sets the data length: 0→5, 1→6, 2→7 and 3→8 bits. Data bits above the selected length are not sent.
- R4: `par_mode_i` sets parity. 0 and 3 mean no parity bit. 1 means odd parity, where the data ones plus the parity bit make an odd count. 2 means even parity.
- R5: `two_stop_i`=0 sends one stop bit and `two_stop_i`=1 sends two.
- R6: `rate_i` sets how many `bit_en_i` pulses each bit lasts: 0→1, 1→16, 2 or 3→64.
- R7: `tx_rdy_o` falls on the cycle after a write is accepted. It rises again on the cycle after the byte moves into the shifter.
- R8: `tx_empty_o` is 0 from the load of a frame until its last stop bit ends. It then returns to 1 if no byte is waiting.
- R9: If a byte is waiting when a frame's last stop bit ends, the next start bit follows at once, with no idle bit time.
- R10: A write while `tx_rdy_o`=0 is dropped: the held byte is kept and the written one is never sent. The write also sets `overrun_o`, which stays set until reset.
- R11: A frame starts only while `tx_en_i`=1. Dropping `tx_en_i` during a frame does not cut that frame short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable pulse |
| rate_i | input | 2 | Enable pulses per bit: 0=1, 1=16, 2/3=64 |
| char_len_i | input | 2 | Data length code: 5 plus the code |
| par_mode_i | input | 2 | 0/3 none, 1 odd, 2 even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| tx_en_i | input | 1 | Permits new frames to start |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial line |
| tx_rdy_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | No frame in progress |
| overrun_o | output | 1 | Sticky flag for a write to a full holding register |

## Verification
The bit-count register and the timer counter are never visible directly. If either is wrong, the fault shows on `txd_o` within one frame: a stop bit is clipped, an extra bit appears, a frame is cut short, or the bit cells are stretched. Every frame is captured whole at mid-bit and compared with a frame rebuilt from its configuration. A holding-register fault shows up as a lost or duplicated frame, or as a gap between back-to-back frames. It is also seen in the ready and overrun flags on the cycle after the offending write.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_EVEN  = 2'd2,
    PAR_NONE3 = 2'd3
  } par_e;

  typedef enum logic [1:0] {
    RATE_X1   = 2'd0,
    RATE_X16  = 2'd1,
    RATE_X64  = 2'd2,
    RATE_X64B = 2'd3
  } rate_e;

  localparam int unsigned MIN_LEN_OFS = 3;  // shortest length is DATA_W - 3
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_HI  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       bit_en_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  localparam int unsigned CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    unique case (rate_i)
      tx_pkg::RATE_X1:  lim = '0;
      tx_pkg::RATE_X16: lim = CNT_W'(DIV_MID - 1);
      default:          lim = CNT_W'(DIV_HI - 1);
    endcase
  end

  assign tick_o = run_i && bit_en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (bit_en_i) cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0)); // R6
  AST_TICK_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |-> !tick_o); // R6
endmodule

// File: rtl/tx_hold.sv
module tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              overrun_o
);
  logic              full_q;
  logic              ovr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i && !full_q) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      if (wr_i && full_q) ovr_q <= 1'b1;
    end
  end

  assign full_o    = full_q;
  assign data_o    = data_q;
  assign overrun_o = ovr_q;

  AST_TAKE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !full_o); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R10
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> ($stable(data_o) && overrun_o)); // R10
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        len_i,
  input  logic [1:0]        par_i,
  input  logic              two_stop_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              last_o,
  output logic              txd_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   left_q;
  logic [CNT_W-1:0]   nbits;
  logic               busy_q;
  logic               has_par;
  logic               ones;
  int unsigned        len;

  // wire order: frame[0] first
  always_comb begin
    len     = DATA_W - tx_pkg::MIN_LEN_OFS + 32'(len_i);
    has_par = (par_i == tx_pkg::PAR_ODD) || (par_i == tx_pkg::PAR_EVEN);
    ones    = 1'b0;
    frame   = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(len)) begin
        frame[i+1] = data_i[i];
        ones       = ones ^ data_i[i];
      end
    end
    if (has_par) frame[len+1] = (par_i == tx_pkg::PAR_ODD) ? ~ones : ones;
    nbits = CNT_W'(len + 2 + 32'(has_par) + 32'(two_stop_i));
  end

  assign last_o = busy_q && tick_i && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame;
      left_q <= nbits;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !txd_o); // R2
  AST_LAST_IS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && left_q == CNT_W'(1)) |-> txd_o); // R5
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!busy_q || last_o)); // R9
endmodule

// File: rtl/async_tx_core.sv
module async_tx_core #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_MID = 16,
  parameter int unsigned DIV_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [1:0]        rate_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  input  logic              tx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o,
  output logic              overrun_o
);
  localparam int unsigned FRAME_W = DATA_W + 4;

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              busy;
  logic              last;
  logic              tick;
  logic              load;

  assign load = hold_full && tx_en_i && (!busy || last);

  tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .data_i    (wr_data_i),
    .take_i    (load),
    .full_o    (hold_full),
    .data_o    (hold_data),
    .overrun_o (overrun_o)
  );

  tx_bit_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy),
    .bit_en_i (bit_en_i),
    .rate_i   (rate_i),
    .tick_o   (tick)
  );

  tx_shifter #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .data_i     (hold_data),
    .len_i      (char_len_i),
    .par_i      (par_mode_i),
    .two_stop_i (two_stop_i),
    .tick_i     (tick),
    .busy_o     (busy),
    .last_o     (last),
    .txd_o      (txd_o)
  );

  assign tx_rdy_o   = !hold_full;
  assign tx_empty_o = !busy;

  AST_RDY_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_rdy_o) |=> !tx_rdy_o); // R7
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && tx_empty_o) |=> tx_empty_o); // R11
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !tx_rdy_o && tx_en_i) |=> !tx_empty_o); // R9
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o); // R2
endmodule

// File: tb/sim_async_tx_core.sv
module sim_async_tx_core;
  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] len;
    logic [1:0] par;
    logic       two;
    logic [7:0] data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd3, 2'd0, 1'b1, 8'h49},
    '{2'd1, 2'd2, 2'd0, 1'b1, 8'hC7},
    '{2'd0, 2'd0, 2'd1, 1'b0, 8'hF5},
    '{2'd2, 2'd1, 2'd2, 1'b0, 8'h2A},
    '{2'd0, 2'd3, 2'd1, 1'b1, 8'hA5},
    '{2'd1, 2'd3, 2'd2, 1'b0, 8'hFF},
    '{2'd3, 2'd0, 2'd3, 1'b0, 8'h03}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b1;
  logic [1:0] rate = 2'd0;
  logic [1:0] clen = 2'd3;
  logic [1:0] par = 2'd0;
  logic       two = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, rdy, empty, ovr;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  async_tx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .rate_i(rate),
    .char_len_i(clen), .par_mode_i(par), .two_stop_i(two), .tx_en_i(tx_en),
    .wr_i(wr), .wr_data_i(wdata), .txd_o(txd), .tx_rdy_o(rdy),
    .tx_empty_o(empty), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int divf(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64;
  endfunction

  function automatic void build(input logic [1:0] l, input logic [1:0] p, input logic t,
                                input logic [7:0] d, output logic [23:0] f, output int n);
    int  ln = 5 + int'(l);
    int  idx;
    logic o = 1'b0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < ln; i++) begin
      f[1+i] = d[i];
      o = o ^ d[i];
    end
    idx = 1 + ln;
    if (p == 2'd1) begin f[idx] = ~o; idx++; end
    else if (p == 2'd2) begin f[idx] = o; idx++; end
    n = idx + 1 + int'(t);
  endfunction

  task automatic capture(input int nbits, input int dv, input int drop_at, output logic [23:0] got);
    int w = 0;
    got = '1;
    while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    chk(txd === 1'b0, "R2 start bit seen", txd, 0);
    repeat (dv / 2) @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < nbits; k++) begin
      repeat (dv) @(negedge clk);
      if (k == drop_at) tx_en = 1'b0;
      got[k] = txd;
    end
  endtask

  task automatic write(input logic [7:0] d);
    wdata = d;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] got, ef, ef2;
    int n, n2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(rdy === 1'b1, "R1 ready after reset", rdy, 1);
    chk(empty === 1'b1, "R1 empty after reset", empty, 1);
    chk(ovr === 1'b0, "R1 overrun after reset", ovr, 0);

    // table-driven frames
    tx_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      rate = VEC[v].rate; clen = VEC[v].len; par = VEC[v].par; two = VEC[v].two;
      build(VEC[v].len, VEC[v].par, VEC[v].two, VEC[v].data, ef, n);
      write(VEC[v].data);
      capture(n, divf(VEC[v].rate), -1, got);
      chk((got & ((24'd1 << n) - 1)) == (ef & ((24'd1 << n) - 1)),
          "R2 R3 R4 R5 R6 frame", int'(got), int'(ef));
      repeat (divf(VEC[v].rate) + 2) @(negedge clk);
      chk(empty === 1'b1 && txd === 1'b1, "R8 empty after frame", empty, 1);
    end

    // R11 hold while disabled, R7 ready, R10 overrun
    rate = 2'd0; clen = 2'd3; par = 2'd0; two = 1'b0;
    tx_en = 1'b0;
    write(8'h5A);
    chk(rdy === 1'b0, "R7 ready low after write", rdy, 0);
    repeat (20) @(negedge clk);
    chk(empty === 1'b1 && txd === 1'b1, "R11 no start while disabled", txd, 1);
    write(8'h33);
    chk(ovr === 1'b1, "R10 overrun set", ovr, 1);
    chk(rdy === 1'b0, "R10 ready still low", rdy, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(rdy === 1'b1, "R7 ready back after load", rdy, 1);
    chk(empty === 1'b0, "R8 empty low during frame", empty, 0);
    build(2'd3, 2'd0, 1'b0, 8'h5A, ef, n);
    capture(n, 1, -1, got);
    chk(got[9:0] == ef[9:0], "R10 held byte kept", int'(got[9:0]), int'(ef[9:0]));
    repeat (10) @(negedge clk);
    chk(empty === 1'b1 && txd === 1'b1, "R10 dropped byte not sent", empty, 1);

    // R9 back-to-back
    build(2'd3, 2'd0, 1'b0, 8'h81, ef, n);
    build(2'd3, 2'd0, 1'b0, 8'h7E, ef2, n2);
    fork
      capture(n + n2, 1, -1, got);
      begin
        write(8'h81);
        @(negedge clk);
        write(8'h7E);
      end
    join
    ef = (ef & ((24'd1 << n) - 1)) | (ef2 << n);
    chk(got[19:0] == ef[19:0], "R9 frames without gap", int'(got[19:0]), int'(ef[19:0]));
    chk(ovr === 1'b1, "R10 overrun stays set", ovr, 1);

    // R11 frame completes after mid-frame disable
    rate = 2'd1; two = 1'b1;
    build(2'd3, 2'd0, 1'b1, 8'h96, ef, n);
    fork
      capture(n, 16, 4, got);
      write(8'h96);
    join
    chk(got[10:0] == ef[10:0], "R11 frame completes", int'(got[10:0]), int'(ef[10:0]));
    write(8'h11);
    repeat (40) @(negedge clk);
    chk(empty === 1'b1 && txd === 1'b1, "R11 disabled after frame", empty, 1);

    // R1 reset clears overrun
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovr === 1'b0 && rdy === 1'b1, "R1 reset clears overrun", ovr, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule